// File: doc/BRIEF.md
# Majority-Vote UART Receiver with Per-Word Error Queue

This block is the receive half of an asynchronous serial port. It watches the RX line on a clock enable that runs at sixteen times the baud rate. A falling edge on the idle-high line opens a frame, and the block confirms that start bit at its centre so that a short glitch is thrown away. Every bit of the frame, including the start, parity and stop bits, is taken as three consecutive samples in the middle of the bit time. The bit value is the majority of the three. If the samples of any bit disagree, the word is marked as noisy.

Each completed word is written into a 128-entry queue together with three flags: parity error, framing error and noise. The host pops words oldest first. A pop loads the data output and the three status outputs with that word's values, so the error bits always belong to the byte just read. The block also provides a fill-level readout, a threshold interrupt programmed in steps of eight entries, a sticky overrun flag, a receive-disable control that lets a frame in progress finish, an RX polarity inversion and a queue flush.

Top module: `uart_rx_vote`

## Requirements
- R1: The line idles high. A frame opens only on a high-to-low change seen between two consecutive sample ticks. If the majority of the start bit's three centre samples is high, the frame is abandoned and no word is stored.
- R2: Each bit lasts 16 sample ticks, counting from 0 at the tick after the start edge. The bit is sampled at ticks 7, 8 and 9 and its value is the majority of the three. The 8 data bits arrive LSB first, and bit 0 of popData is the first data bit received.
- R3: statusNoise of a word is 1 if the three samples of any of its bits (start, data, parity or stop) were not all equal. Otherwise it is 0.
- R4: When cfgParityEn is 1, one parity bit follows the data. When cfgParityOdd is 0, the data bits plus the parity bit must contain an even number of ones. When cfgParityOdd is 1, they must contain an odd number of ones. A mismatch sets statusParity. When cfgParityEn is 0, no parity bit is expected and statusParity is 0.
- R5: statusFrame of a word is 1 when the majority value of its stop bit is 0.
- R6: RX passes through a two-stage synchroniser. A word is written into the queue at the third stop-bit sample. With the tick high on every cycle, fillLevel rises on the clock edge 13+16·k cycles after RX falls, where k is 9 without parity and 10 with parity. A pop on a non-empty queue loads popData and the three status outputs on the next edge with the oldest word, which is then removed. A pop on an empty queue changes nothing.
- R7: fillLevel always equals the number of stored words, from 0 to 128.
- R8: A word that completes while the queue holds 128 words and no pop happens in the same cycle is dropped, and overrun is set and stays set. A push and a pop in the same cycle on a full queue both take effect.
- R9: trigIrq is 1 exactly when fillLevel is greater than 8·cfgTrigLevel.
- R10: While cfgRxDisable is 1, no new frame is opened. A frame already in progress completes and is stored.
- R11: When cfgInvert is 1, RX is inverted before the synchroniser, so the line idles low.
- R12: fifoClear empties the queue and clears overrun. It takes priority over a pop and over a push in the same cycle.
- R13: After reset, fillLevel, popData, the status outputs, overrun and trigIrq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | Clock enable at 16 times the baud rate |
| rxLine | input | 1 | Serial receive line |
| cfgInvert | input | 1 | Invert RX polarity |
| cfgParityEn | input | 1 | Expect a parity bit after the data |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgRxDisable | input | 1 | Stop opening new frames |
| cfgTrigLevel | input | 4 | Interrupt threshold in units of eight words |
| fifoClear | input | 1 | Flush the queue and clear overrun |
| popReq | input | 1 | Remove the oldest word |
| popData | output | 8 | Data of the last popped word |
| statusParity | output | 1 | Parity error of the last popped word |
| statusFrame | output | 1 | Framing error of the last popped word |
| statusNoise | output | 1 | Noise flag of the last popped word |
| overrun | output | 1 | Sticky flag: a word was dropped on a full queue |
| fillLevel | output | 8 | Number of stored words |
| trigIrq | output | 1 | Fill level above the threshold |

## Verification
The storage of a newly completed word and a host pop can land on the same clock edge. This matters most when the queue is full, where a simultaneous pop must make room instead of causing an overrun. The bench computes the exact push cycle from the frame's start edge and fires a pop on that cycle. It also fires a flush on a push cycle in a separate case. A queue model in the bench applies flush, then pop, then push on every edge. The bench compares its level, interrupt, overrun and popped word against the outputs on every clock.

// File: rtl/uart_rx_vote_pkg.sv
package uart_rx_vote_pkg;

  localparam int RX_DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clearWord;    // a new frame opens: reset the per-word accumulators
    logic takeS0;       // capture the first centre sample
    logic takeS1;       // capture the second centre sample
    logic voteBit;      // third sample: resolve the bit, fold in its noise
    logic shiftData;    // the resolved bit is a data bit
    logic checkParity;  // the resolved bit is the parity bit
    logic pushWord;     // the resolved bit is the stop bit: store the word
  } rxStrobe_t;

  typedef struct packed {
    logic                 noise;
    logic                 frame;
    logic                 parity;
    logic [RX_DATA_W-1:0] data;
  } rxWord_t;

endpackage

// File: rtl/uart_rx_vote_ctrl.sv
module uart_rx_vote_ctrl
  import uart_rx_vote_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineS,
  input  logic      voteVal,
  input  logic      cfgParityEn,
  input  logic      cfgRxDisable,
  output rxStrobe_t strb
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(RX_DATA_W);
  localparam logic [CNT_W-1:0] TICK_S0   = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] TICK_S1   = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] TICK_VOTE = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(RX_DATA_W - 1);

  rxState_e         state, stateNext;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             prevLine;
  logic             atS0, atS1, atVote, atLast;

  assign atS0   = (tickCnt == TICK_S0);
  assign atS1   = (tickCnt == TICK_S1);
  assign atVote = (tickCnt == TICK_VOTE);
  assign atLast = (tickCnt == TICK_LAST);

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (sampleTick) begin
      if (state != ST_IDLE) begin
        strb.takeS0 = atS0;
        strb.takeS1 = atS1;
        strb.voteBit = atVote;
      end
      case (state)
        ST_IDLE: begin
          if (!cfgRxDisable && prevLine && !lineS) begin
            stateNext      = ST_START;
            strb.clearWord = 1'b1;
          end
        end
        ST_START: begin
          if (atVote && voteVal) stateNext = ST_IDLE;
          else if (atLast) stateNext = ST_DATA;
        end
        ST_DATA: begin
          strb.shiftData = atVote;
          if (atLast && bitIdx == IDX_LAST)
            stateNext = cfgParityEn ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: begin
          strb.checkParity = atVote;
          if (atLast) stateNext = ST_STOP;
        end
        ST_STOP: begin
          if (atVote) begin
            strb.pushWord = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      prevLine <= 1'b1;
    end else begin
      state <= stateNext;
      if (sampleTick) begin
        prevLine <= lineS;
        if (state == ST_IDLE || stateNext == ST_IDLE || atLast)
          tickCnt <= '0;
        else
          tickCnt <= tickCnt + CNT_W'(1);
        if (state == ST_START)
          bitIdx <= '0;
        else if (state == ST_DATA && atLast)
          bitIdx <= bitIdx + IDX_W'(1);
      end
    end
  end

  // R10: a disabled receiver sitting idle stays idle
  a_r10_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cfgRxDisable) |=> (state == ST_IDLE));

  // R1: a frame opens only after the line was seen high
  a_r1_start_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !prevLine) |=> (state == ST_IDLE));

  // R2: at most one sampling action per tick
  a_r2_one_sample_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeS0, strb.takeS1, strb.voteBit}));

  // R2: a word is stored only out of the stop state
  a_r2_push_from_stop: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushWord |-> (state == ST_STOP));

endmodule

// File: rtl/uart_rx_vote_dp.sv
module uart_rx_vote_dp
  import uart_rx_vote_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int TRIG_W    = 4,
  parameter int TRIG_STEP = 8,
  parameter int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 cfgInvert,
  input  logic                 cfgParityOdd,
  input  logic [TRIG_W-1:0]    cfgTrigLevel,
  input  rxStrobe_t            strb,
  input  logic                 popReq,
  input  logic                 fifoClear,
  output logic                 lineS,
  output logic                 voteVal,
  output logic [RX_DATA_W-1:0] popData,
  output logic                 statusParity,
  output logic                 statusFrame,
  output logic                 statusNoise,
  output logic                 overrun,
  output logic [LVL_W-1:0]     fillLevel,
  output logic                 trigIrq
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  // ---------------- input conditioning and bit resolution ----------------
  logic [1:0]           syncQ;
  logic                 samp0, samp1;
  logic                 bitNoisy;
  logic [RX_DATA_W-1:0] shiftReg;
  logic                 parAcc, parErr, noiseAcc;
  rxWord_t              newWord;

  assign lineS    = syncQ[1];
  assign voteVal  = (samp0 & samp1) | (samp0 & lineS) | (samp1 & lineS);
  assign bitNoisy = !((samp0 == samp1) && (samp1 == lineS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      samp0    <= 1'b1;
      samp1    <= 1'b1;
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parErr   <= 1'b0;
      noiseAcc <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxLine ^ cfgInvert};
      if (strb.takeS0) samp0 <= lineS;
      if (strb.takeS1) samp1 <= lineS;
      if (strb.clearWord) begin
        parAcc   <= 1'b0;
        parErr   <= 1'b0;
        noiseAcc <= 1'b0;
      end else begin
        if (strb.voteBit && bitNoisy) noiseAcc <= 1'b1;
        if (strb.shiftData) begin
          shiftReg <= {voteVal, shiftReg[RX_DATA_W-1:1]};
          parAcc   <= parAcc ^ voteVal;
        end
        if (strb.checkParity) parErr <= parAcc ^ voteVal ^ cfgParityOdd;
      end
    end
  end

  assign newWord.noise  = noiseAcc | bitNoisy;
  assign newWord.frame  = !voteVal;
  assign newWord.parity = parErr;
  assign newWord.data   = shiftReg;

  // ---------------- receive queue ----------------
  rxWord_t          mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic             popOk, pushOk;
  logic [LVL_W-1:0] trigThresh;

  assign popOk  = popReq && (count != '0);
  assign pushOk = strb.pushWord && ((count != LVL_FULL) || popOk);

  always_ff @(posedge clk) begin
    if (pushOk && !fifoClear) mem[wrPtr] <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      count        <= '0;
      overrun      <= 1'b0;
      popData      <= '0;
      statusParity <= 1'b0;
      statusFrame  <= 1'b0;
      statusNoise  <= 1'b0;
    end else if (fifoClear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (popOk) begin
        popData      <= mem[rdPtr].data;
        statusParity <= mem[rdPtr].parity;
        statusFrame  <= mem[rdPtr].frame;
        statusNoise  <= mem[rdPtr].noise;
        rdPtr        <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      end
      if (pushOk) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (strb.pushWord && !pushOk) overrun <= 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + LVL_W'(1);
        2'b01:   count <= count - LVL_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign trigThresh = LVL_W'(cfgTrigLevel) * LVL_W'(TRIG_STEP);
  assign trigIrq    = (count > trigThresh);
  assign fillLevel  = count;

  // R7: the level never exceeds the queue depth
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= LVL_FULL);

  // R7: outside a flush the level moves by at most one per cycle
  a_r7_level_step: assert property (@(posedge clk) disable iff (!rstN)
    !fifoClear |=> (count == $past(count)) || (count == $past(count) + LVL_W'(1))
                   || (count == $past(count) - LVL_W'(1)));

  // R8: overrun stays set until a flush
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !fifoClear) |=> overrun);

  // R6: a pop on an empty queue leaves the read outputs untouched
  a_r6_empty_pop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && count == '0) |=> ($stable(popData) && $stable(statusNoise)));

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
  import uart_rx_vote_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int OVS       = 16,
  parameter int TRIG_W    = 4,
  parameter int TRIG_STEP = 8,
  parameter int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 cfgInvert,
  input  logic                 cfgParityEn,
  input  logic                 cfgParityOdd,
  input  logic                 cfgRxDisable,
  input  logic [TRIG_W-1:0]    cfgTrigLevel,
  input  logic                 fifoClear,
  input  logic                 popReq,
  output logic [RX_DATA_W-1:0] popData,
  output logic                 statusParity,
  output logic                 statusFrame,
  output logic                 statusNoise,
  output logic                 overrun,
  output logic [LVL_W-1:0]     fillLevel,
  output logic                 trigIrq
);

  rxStrobe_t strb;
  logic      lineS;
  logic      voteVal;

  uart_rx_vote_ctrl #(.OVS(OVS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleTick   (sampleTick),
    .lineS        (lineS),
    .voteVal      (voteVal),
    .cfgParityEn  (cfgParityEn),
    .cfgRxDisable (cfgRxDisable),
    .strb         (strb)
  );

  uart_rx_vote_dp #(
    .DEPTH     (DEPTH),
    .TRIG_W    (TRIG_W),
    .TRIG_STEP (TRIG_STEP),
    .LVL_W     (LVL_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .rxLine       (rxLine),
    .cfgInvert    (cfgInvert),
    .cfgParityOdd (cfgParityOdd),
    .cfgTrigLevel (cfgTrigLevel),
    .strb         (strb),
    .popReq       (popReq),
    .fifoClear    (fifoClear),
    .lineS        (lineS),
    .voteVal      (voteVal),
    .popData      (popData),
    .statusParity (statusParity),
    .statusFrame  (statusFrame),
    .statusNoise  (statusNoise),
    .overrun      (overrun),
    .fillLevel    (fillLevel),
    .trigIrq      (trigIrq)
  );

endmodule

// File: tb/uart_rx_vote_tb.sv
`timescale 1ns/1ps
module uart_rx_vote_tb;

  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       rxLine = 1'b1;
  logic       cfgInvert = 1'b0, cfgParityEn = 1'b0, cfgParityOdd = 1'b0;
  logic       cfgRxDisable = 1'b0;
  logic [3:0] cfgTrigLevel = 4'd0;
  logic       fifoClear = 1'b0, popReq = 1'b0;
  logic [7:0] popData;
  logic       statusParity, statusFrame, statusNoise, overrun, trigIrq;
  logic [7:0] fillLevel;

  uart_rx_vote u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .cfgInvert(cfgInvert), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgRxDisable(cfgRxDisable), .cfgTrigLevel(cfgTrigLevel), .fifoClear(fifoClear),
    .popReq(popReq), .popData(popData), .statusParity(statusParity),
    .statusFrame(statusFrame), .statusNoise(statusNoise), .overrun(overrun),
    .fillLevel(fillLevel), .trigIrq(trigIrq)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model: {noise, frame, parity, data} ----------------
  logic [10:0] q[$];
  logic [10:0] mPop = '0;
  bit          mOver = 1'b0;
  bit          pendValid = 1'b0;
  int          pendCyc = 0;
  logic [10:0] pendWord = '0;
  int          cyc = 0;
  bit          chkOn = 1'b0;

  always @(posedge clk) begin
    bit popNow, pushNow;
    cyc = cyc + 1;
    popNow  = popReq && (q.size() > 0);
    pushNow = pendValid && (pendCyc == cyc);
    if (pushNow) pendValid = 1'b0;
    if (fifoClear) begin
      q.delete();
      mOver = 1'b0;
    end else begin
      if (popNow) mPop = q.pop_front();
      if (pushNow) begin
        if (q.size() < DEPTH) q.push_back(pendWord);
        else mOver = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (chkOn) begin
      chk(fillLevel == q.size(), "R7 fill level", fillLevel, q.size());
      chk(trigIrq == (q.size() > cfgTrigLevel * 8), "R9 trigger", trigIrq,
          int'(q.size() > cfgTrigLevel * 8));
      chk(overrun == mOver, "R8 overrun", overrun, mOver);
      chk(popData == mPop[7:0], "R6 popped data", popData, mPop[7:0]);
      chk({statusNoise, statusFrame, statusParity} == mPop[10:8], "R6 popped flags",
          {statusNoise, statusFrame, statusParity}, mPop[10:8]);
    end
  end

  // ---------------- stimulus helpers ----------------
  // Drive one frame from a negedge. noiseBit is the frame bit index (0 = start) that
  // gets one flipped centre sample, or -1 for a clean frame.
  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit stopVal,
                           input int noiseBit, input bit expectPush);
    logic [10:0] bits;
    int          n;
    logic        v;
    n = cfgParityEn ? 10 : 9;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    if (cfgParityEn) bits[9] = (^d) ^ cfgParityOdd ^ badPar;
    bits[n] = stopVal;
    if (expectPush) begin
      pendWord  = {noiseBit >= 0, !stopVal, cfgParityEn & badPar, d};
      pendCyc   = cyc + 13 + 16 * n;
      pendValid = 1'b1;
    end
    for (int w = 0; w < 16 * (n + 1); w++) begin
      v = bits[w / 16];
      if ((w / 16) == noiseBit && (w % 16) == 9) v = !v;
      rxLine = v ^ cfgInvert;
      @(negedge clk);
    end
    rxLine = 1'b1 ^ cfgInvert;
    repeat (4) @(negedge clk);
  endtask

  task automatic popCheck(input logic [7:0] d, input logic [2:0] nfp, input string tag);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    chk(popData == d, {tag, " data"}, popData, d);
    chk({statusNoise, statusFrame, statusParity} == nfp, {tag, " flags"},
        {statusNoise, statusFrame, statusParity}, nfp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk(fillLevel == 0, "R13 level", fillLevel, 0);
    chk(popData == 0 && !statusParity && !statusFrame && !statusNoise, "R13 read outputs",
        popData, 0);
    chk(!overrun && !trigIrq, "R13 flags", {overrun, trigIrq}, 0);
    chkOn = 1'b1;

    // R2: clean frame, no parity, LSB first
    sendFrame(8'hA5, 0, 1, -1, 1);
    popCheck(8'hA5, 3'b000, "R2 clean word");
    sendFrame(8'h01, 0, 1, -1, 1);
    popCheck(8'h01, 3'b000, "R2 lsb first");

    // R3: one disagreeing sample on a data, start and stop bit
    sendFrame(8'h3C, 0, 1, 4, 1);
    popCheck(8'h3C, 3'b100, "R3 noise on data");
    sendFrame(8'hC3, 0, 1, 0, 1);
    popCheck(8'hC3, 3'b100, "R3 noise on start");
    sendFrame(8'h5A, 0, 1, 9, 1);
    popCheck(8'h5A, 3'b100, "R3 noise on stop");

    // R4: even and odd parity, good and bad
    cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    sendFrame(8'h81, 0, 1, -1, 1);
    popCheck(8'h81, 3'b000, "R4 even good");
    sendFrame(8'h81, 1, 1, -1, 1);
    popCheck(8'h81, 3'b001, "R4 even bad");
    cfgParityOdd = 1'b1;
    sendFrame(8'h07, 0, 1, 10, 1);
    popCheck(8'h07, 3'b100, "R4 odd good, noisy stop");
    sendFrame(8'h07, 1, 1, -1, 1);
    popCheck(8'h07, 3'b001, "R4 odd bad");
    cfgParityEn = 1'b0; cfgParityOdd = 1'b0;

    // R5: stop bit low
    sendFrame(8'hE1, 0, 0, -1, 1);
    popCheck(8'hE1, 3'b010, "R5 framing");

    // R1: a 4-cycle low glitch opens no frame
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    chk(fillLevel == 0, "R1 glitch rejected", fillLevel, 0);

    // R10: disabled receiver ignores a frame, but finishes one already started
    cfgRxDisable = 1'b1;
    sendFrame(8'h66, 0, 1, -1, 0);
    chk(fillLevel == 0, "R10 disabled ignores", fillLevel, 0);
    cfgRxDisable = 1'b0;
    fork
      sendFrame(8'h99, 0, 1, -1, 1);
      begin repeat (40) @(negedge clk); cfgRxDisable = 1'b1; end
    join
    chk(fillLevel == 1, "R10 frame in progress kept", fillLevel, 1);
    cfgRxDisable = 1'b0;
    popCheck(8'h99, 3'b000, "R10 kept word");

    // R11: inverted line
    cfgInvert = 1'b1; rxLine = 1'b0;
    repeat (4) @(negedge clk);
    sendFrame(8'h96, 0, 1, -1, 1);
    popCheck(8'h96, 3'b000, "R11 inverted");
    cfgInvert = 1'b0; rxLine = 1'b1;
    repeat (4) @(negedge clk);

    // R6: pop on empty changes nothing
    popCheck(8'h96, 3'b000, "R6 empty pop");

    // R9: threshold
    cfgTrigLevel = 4'd0;
    sendFrame(8'h11, 0, 1, -1, 1);
    chk(trigIrq == 1'b1, "R9 level 1 above 0", trigIrq, 1);
    cfgTrigLevel = 4'd1;
    @(negedge clk);
    chk(trigIrq == 1'b0, "R9 level 1 not above 8", trigIrq, 0);
    popCheck(8'h11, 3'b000, "R6 drain");

    // R7/R8/R9: fill to full, overflow, same-cycle push and pop
    cfgTrigLevel = 4'd15;
    for (int i = 0; i < DEPTH; i++) begin
      sendFrame(8'(i), 0, 1, -1, 1);
      if (i == 119) chk(trigIrq == 1'b0, "R9 level 120", trigIrq, 0);
      if (i == 120) chk(trigIrq == 1'b1, "R9 level 121", trigIrq, 1);
    end
    chk(fillLevel == DEPTH, "R7 full level", fillLevel, DEPTH);
    sendFrame(8'hAA, 0, 1, -1, 1);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    chk(fillLevel == DEPTH, "R8 dropped word", fillLevel, DEPTH);
    fork
      sendFrame(8'h55, 0, 1, -1, 1);
      begin
        repeat (16 * 9 + 12) @(negedge clk);
        popReq = 1'b1;
        @(negedge clk);
        popReq = 1'b0;
      end
    join
    chk(fillLevel == DEPTH, "R8 push with pop at full", fillLevel, DEPTH);
    chk(popData == 8'h00, "R8 pop at full", popData, 0);
    for (int i = 1; i < DEPTH; i++) popCheck(8'(i), 3'b000, "R6 oldest first");
    popCheck(8'h55, 3'b000, "R8 word stored beside pop");
    chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

    // R12: flush
    sendFrame(8'h12, 0, 1, -1, 1);
    sendFrame(8'h34, 0, 1, -1, 1);
    fifoClear = 1'b1; popReq = 1'b1;
    @(negedge clk);
    fifoClear = 1'b0; popReq = 1'b0;
    chk(fillLevel == 0, "R12 flush empties", fillLevel, 0);
    chk(overrun == 1'b0, "R12 flush clears overrun", overrun, 0);
    chk(popData == 8'h55, "R12 flush beats pop", popData, 8'h55);
    fork
      sendFrame(8'h78, 0, 1, -1, 1);
      begin
        repeat (16 * 9 + 12) @(negedge clk);
        fifoClear = 1'b1;
        @(negedge clk);
        fifoClear = 1'b0;
      end
    join
    chk(fillLevel == 0, "R12 flush beats push", fillLevel, 0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule